// File: doc/BRIEF.md
# Programmable Gate Pulse Generator

This block produces a periodic measurement gate for a frequency-counting datapath. It keeps a free-running 32-bit counter of the reference clock and a compare register. Each time the counter equals the compare value, the gate output flips and the compare value moves forward by an interval added to itself. The counter is never reloaded, so the schedule has no cumulative drift and stays correct when the counter wraps. Each gate period has a high phase of fixed length, 40 ms worth of reference cycles, followed by a low phase that fills the rest of the requested period. The gate output feeds the capture inputs of a counter block.

Software programs the block through a small write port. One register holds the reference frequency in Hz. Writing it starts a recalculation that uses a state machine with two sequential constant dividers. The recalculation derives the high-phase length (frequency / 25) and the permitted period range: a floor of frequency / 20, which is 50 ms, and a ceiling of frequency * 60, which is 60 s. The other register takes a gate period in reference cycles. That period is clamped into the range, turned into a low-phase length and held pending. The pending pair is copied into the active schedule only at a high-to-low toggle, so a change never cuts a phase short.

The settings unit has three states. SET_IDLE accepts writes. A frequency write moves it to SET_DIVIDE, where it stays while the dividers run. Once both quotients are ready it moves to SET_STORE. SET_STORE latches the new limits and returns to SET_IDLE. The phase unit has two states. PH_LOW moves to PH_HIGH on a compare match and schedules the high interval. PH_HIGH moves to PH_LOW on a match, schedules the low interval and applies any pending setting.

Top module: `gate_pulse_gen`

## Requirements
- R1: While the synchronous active-low reset `rst_n` is low, `gate_o` is 0 and the counter is held at 0. Reset loads the default schedule: high = max(floor(DEF_REF_HZ/25),1) and low = max(DEF_REF_HZ - high,1). Reset also clears the pending flag.
- R2: After reset is released, the first compare point equals the counter start (0) plus the default high length. `gate_o` first rises on clock edge number high+1 after release, counting the first edge at which `rst_n` is sampled high as edge 1.
- R3: `gate_o` changes only on an edge where counter == compare. On every such edge it toggles, and the compare value advances by the interval, modulo 2^32. The counter increments by one on every edge outside reset.
- R4: A high phase lasts exactly the active high length in clock cycles. A low phase lasts exactly the low length that was active when that low phase began.
- R5: A write with `cfg_sel`=1 stores `cfg_wdata` as the reference frequency f. The high length for later period writes is then max(floor(f/25),1).
- R6: A write with `cfg_sel`=0 is a gate period P in cycles. P is clamped to [floor(f/20), min(f*60, 2^32-1)]. The low length is clamped P minus high, or 1 if that is not positive.
- R7: A pending setting is applied only at a high-to-low toggle. The low phase that begins at that toggle still uses the previous low length. The next high phase and everything after it use the new pair.
- R8: While a recalculation is running (from the frequency write until the return to SET_IDLE, at most 36 cycles), every write of either kind is ignored.
- R9: An accepted period write sets the pending flag two edges after it is sampled. A high-to-low toggle with no write arriving in the same cycle clears the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; the counter counts these edges |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_wr | input | 1 | Write strobe, one cycle per write |
| cfg_sel | input | 1 | 0: gate period in cycles, 1: reference frequency in Hz |
| cfg_wdata | input | 32 | Write data |
| gate_o | output | 1 | Measurement gate |

## Verification
The bench measures every high and low phase and compares each length with a bench model of the active and pending schedules. A design that applied an update immediately, or at a rising toggle, would show a phase of the wrong length right after the write. Writes are placed both inside a high phase and inside a low phase, so both apply orderings are covered. Directed cases cover the following:
- Periods below the floor and above the ceiling. A design that skipped or swapped a clamp would produce the wrong low length.
- A tiny frequency that makes the low length floor at one cycle. Without that floor the gate would stall for a whole counter wrap.
- Writes issued back to back during a recalculation. A design that accepted them would change the high length or start a stray period.

// File: rtl/gp_pkg.sv
package gp_pkg;

    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } phase_e;

    typedef enum logic [1:0] {
        SET_IDLE   = 2'd0,
        SET_DIVIDE = 2'd1,
        SET_STORE  = 2'd2
    } set_state_e;

    // Ratios of the reference frequency that fix the schedule
    localparam int unsigned HIGH_DIV  = 25;  // 40 ms high phase
    localparam int unsigned FLOOR_DIV = 20;  // 50 ms shortest period
    localparam int unsigned CEIL_MUL  = 60;  // 60 s longest period

endpackage

// File: rtl/gp_const_div.sv
// Sequential restoring divider by a constant; one quotient bit per cycle.
module gp_const_div #(
    parameter int W       = 32,
    parameter int DIVISOR = 25
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] dividend,
    output logic         busy,
    output logic [W-1:0] quotient
);
    localparam int RW = $clog2(DIVISOR + 1);
    localparam int SW = $clog2(W + 1);
    localparam logic [RW:0] DVS = (RW + 1)'(DIVISOR);

    logic [RW-1:0] rem_q;
    logic [W-1:0]  shift_q;
    logic [SW-1:0] steps_q;
    logic          run_q;
    logic [RW:0]   trial;

    assign trial = {rem_q, shift_q[W-1]};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q   <= 1'b0;
            rem_q   <= '0;
            shift_q <= '0;
            steps_q <= '0;
        end else if (start && !run_q) begin
            run_q   <= 1'b1;
            rem_q   <= '0;
            shift_q <= dividend;
            steps_q <= SW'(W);
        end else if (run_q) begin
            if (trial >= DVS) begin
                rem_q   <= RW'(trial - DVS);
                shift_q <= {shift_q[W-2:0], 1'b1};
            end else begin
                rem_q   <= trial[RW-1:0];
                shift_q <= {shift_q[W-2:0], 1'b0};
            end
            steps_q <= steps_q - 1'b1;
            if (steps_q == SW'(1)) run_q <= 1'b0;
        end
    end

    assign busy     = run_q;
    assign quotient = shift_q;
endmodule

// File: rtl/gp_settings.sv
// Register writes, limit recalculation and period-to-interval conversion.
module gp_settings
    import gp_pkg::*;
#(
    parameter int         W       = 32,
    parameter logic [W-1:0] DEF_REF = W'(100_000_000),
    parameter logic [W-1:0] DEF_HI  = W'(4_000_000),
    parameter logic [W-1:0] DEF_LO  = W'(96_000_000),
    parameter logic [W-1:0] DEF_MIN = W'(5_000_000),
    parameter logic [W-1:0] DEF_MAX = {W{1'b1}}
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cfg_wr,
    input  logic         cfg_sel,
    input  logic [W-1:0] cfg_wdata,
    output logic         busy,
    output logic         upd_we,
    output logic [W-1:0] upd_hi,
    output logic [W-1:0] upd_lo
);
    localparam int NDIV = 2;
    localparam int PW   = W + 6;

    set_state_e   state_q, state_d;
    logic [W-1:0] freq_q, hi_q, min_q, max_q;
    logic [NDIV-1:0] div_busy;
    logic [W-1:0] div_q [NDIV];
    logic         accept, ref_start, per_write;
    logic [PW-1:0] ceil_prod;
    logic [W-1:0] ceil_sat, per_clamped, lo_calc;

    assign accept    = (state_q == SET_IDLE) && cfg_wr;
    assign ref_start = accept && cfg_sel;
    assign per_write = accept && !cfg_sel;

    // Divider 0 gives the high length, divider 1 the period floor
    for (genvar i = 0; i < NDIV; i++) begin : g_div
        localparam int DV = (i == 0) ? HIGH_DIV : FLOOR_DIV;
        gp_const_div #(.W(W), .DIVISOR(DV)) u_div (
            .clk      (clk),
            .rst_n    (rst_n),
            .start    (ref_start),
            .dividend (cfg_wdata),
            .busy     (div_busy[i]),
            .quotient (div_q[i])
        );
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SET_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SET_IDLE:   if (ref_start)     state_d = SET_DIVIDE;
            SET_DIVIDE: if (div_busy == '0) state_d = SET_STORE;
            SET_STORE:                     state_d = SET_IDLE;
            default:                       state_d = SET_IDLE;
        endcase
    end

    assign busy = (state_q != SET_IDLE);

    // Ceiling: f * 60, saturated to the counter range
    assign ceil_prod = PW'(freq_q) * PW'(CEIL_MUL);
    assign ceil_sat  = (ceil_prod[PW-1:W] != '0) ? {W{1'b1}} : ceil_prod[W-1:0];

    // Clamp the requested period and derive the low interval
    always_comb begin
        if (cfg_wdata < min_q)      per_clamped = min_q;
        else if (cfg_wdata > max_q) per_clamped = max_q;
        else                        per_clamped = cfg_wdata;
        lo_calc = (per_clamped > hi_q) ? (per_clamped - hi_q) : W'(1);
    end

    // Limit registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            freq_q <= DEF_REF;
            hi_q   <= DEF_HI;
            min_q  <= DEF_MIN;
            max_q  <= DEF_MAX;
        end else begin
            if (ref_start) freq_q <= cfg_wdata;
            if (state_q == SET_STORE) begin
                hi_q  <= (div_q[0] == '0) ? W'(1) : div_q[0];
                min_q <= div_q[1];
                max_q <= ceil_sat;
            end
        end
    end

    // Outputs toward the phase unit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upd_we <= 1'b0;
            upd_hi <= DEF_HI;
            upd_lo <= DEF_LO;
        end else begin
            upd_we <= per_write;
            if (per_write) begin
                upd_hi <= hi_q;
                upd_lo <= lo_calc;
            end
        end
    end
endmodule

// File: rtl/gp_phase.sv
// Free-running counter, compare scheduling and gate toggling.
module gp_phase
    import gp_pkg::*;
#(
    parameter int           W      = 32,
    parameter logic [W-1:0] DEF_HI = W'(4_000_000),
    parameter logic [W-1:0] DEF_LO = W'(96_000_000)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         upd_we,
    input  logic [W-1:0] upd_hi,
    input  logic [W-1:0] upd_lo,
    output logic         gate_o,
    output logic [W-1:0] ref_cnt,
    output logic [W-1:0] cmp_val,
    output logic         pend
);
    phase_e       state_q, state_d;
    logic [W-1:0] cnt_q, cmp_q;
    logic [W-1:0] act_hi_q, act_lo_q, pend_hi_q, pend_lo_q;
    logic         pend_q, match;

    assign match = (cnt_q == cmp_q);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PH_LOW;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_LOW:  if (match) state_d = PH_HIGH;
            PH_HIGH: if (match) state_d = PH_LOW;
            default:            state_d = PH_LOW;
        endcase
    end

    // Counter, compare point and schedule registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            cmp_q     <= DEF_HI;
            act_hi_q  <= DEF_HI;
            act_lo_q  <= DEF_LO;
            pend_hi_q <= DEF_HI;
            pend_lo_q <= DEF_LO;
            pend_q    <= 1'b0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
            if (match) begin
                unique case (state_q)
                    PH_LOW: cmp_q <= cmp_q + act_hi_q;
                    PH_HIGH: begin
                        cmp_q <= cmp_q + act_lo_q;
                        if (pend_q) begin
                            act_hi_q <= pend_hi_q;
                            act_lo_q <= pend_lo_q;
                            pend_q   <= 1'b0;
                        end
                    end
                    default: cmp_q <= cmp_q;
                endcase
            end
            if (upd_we) begin
                pend_q    <= 1'b1;
                pend_hi_q <= upd_hi;
                pend_lo_q <= upd_lo;
            end
        end
    end

    // Outputs
    assign gate_o  = (state_q == PH_HIGH);
    assign ref_cnt = cnt_q;
    assign cmp_val = cmp_q;
    assign pend    = pend_q;
endmodule

// File: rtl/gate_pulse_gen.sv
module gate_pulse_gen #(
    parameter int              CNT_W      = 32,
    parameter longint unsigned DEF_REF_HZ = 100_000_000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic             cfg_sel,
    input  logic [CNT_W-1:0] cfg_wdata,
    output logic             gate_o
);
    import gp_pkg::*;

    localparam longint unsigned FULL  = (64'd1 << CNT_W) - 64'd1;
    localparam longint unsigned HI_L  = (DEF_REF_HZ / HIGH_DIV == 0) ? 64'd1 : DEF_REF_HZ / HIGH_DIV;
    localparam longint unsigned LO_L  = (DEF_REF_HZ > HI_L) ? DEF_REF_HZ - HI_L : 64'd1;
    localparam longint unsigned MIN_L = DEF_REF_HZ / FLOOR_DIV;
    localparam longint unsigned MAX_L = (DEF_REF_HZ * CEIL_MUL > FULL) ? FULL : DEF_REF_HZ * CEIL_MUL;

    localparam logic [CNT_W-1:0] DEF_REF = CNT_W'(DEF_REF_HZ);
    localparam logic [CNT_W-1:0] DEF_HI  = CNT_W'(HI_L);
    localparam logic [CNT_W-1:0] DEF_LO  = CNT_W'(LO_L);
    localparam logic [CNT_W-1:0] DEF_MIN = CNT_W'(MIN_L);
    localparam logic [CNT_W-1:0] DEF_MAX = CNT_W'(MAX_L);

    logic             set_busy, upd_we, pend;
    logic [CNT_W-1:0] upd_hi, upd_lo, ref_cnt, cmp_val;

    gp_settings #(
        .W(CNT_W), .DEF_REF(DEF_REF), .DEF_HI(DEF_HI), .DEF_LO(DEF_LO),
        .DEF_MIN(DEF_MIN), .DEF_MAX(DEF_MAX)
    ) u_settings (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .busy      (set_busy),
        .upd_we    (upd_we),
        .upd_hi    (upd_hi),
        .upd_lo    (upd_lo)
    );

    gp_phase #(.W(CNT_W), .DEF_HI(DEF_HI), .DEF_LO(DEF_LO)) u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .upd_we  (upd_we),
        .upd_hi  (upd_hi),
        .upd_lo  (upd_lo),
        .gate_o  (gate_o),
        .ref_cnt (ref_cnt),
        .cmp_val (cmp_val),
        .pend    (pend)
    );
endmodule

// File: rtl/gp_gate_checker.sv
module gp_gate_checker #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         cfg_wr,
    input logic         gate_o,
    input logic [W-1:0] ref_cnt,
    input logic [W-1:0] cmp_val,
    input logic         pend,
    input logic         upd_we,
    input logic         set_busy
);
    // R1: reset forces the gate low
    a_r1_reset_low: assert property (@(posedge clk) !rst_n |=> !gate_o);

    // R3: toggle on every compare match
    a_r3_toggle_on_match: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_cnt == cmp_val) |=> (gate_o != $past(gate_o)));

    // R3: no toggle and no compare change without a match
    a_r3_hold_otherwise: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_cnt != cmp_val) |=> ($stable(gate_o) && $stable(cmp_val)));

    // R3: counter runs freely
    a_r3_count_up: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (ref_cnt == $past(ref_cnt) + 1'b1));

    // R8: writes during recalculation produce no update
    a_r8_busy_ignores: assert property (@(posedge clk) disable iff (!rst_n)
        (set_busy && cfg_wr) |=> !upd_we);

    // R9: falling toggle consumes the pending setting
    a_r9_pend_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && gate_o && (ref_cnt == cmp_val) && !upd_we) |=> !pend);

    // R9: an update sets the pending flag
    a_r9_pend_sets: assert property (@(posedge clk) disable iff (!rst_n)
        upd_we |=> pend);
endmodule

bind gate_pulse_gen gp_gate_checker #(.W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_wr   (cfg_wr),
    .gate_o   (gate_o),
    .ref_cnt  (ref_cnt),
    .cmp_val  (cmp_val),
    .pend     (pend),
    .upd_we   (upd_we),
    .set_busy (set_busy)
);

// File: tb/gate_pulse_gen_test.sv
`timescale 1ns/1ps
module gate_pulse_gen_test;
    localparam longint unsigned REF0 = 1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic        cfg_sel = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        gate_o;

    int errors = 0;
    int checks = 0;

    gate_pulse_gen #(.CNT_W(32), .DEF_REF_HZ(REF0)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .gate_o(gate_o)
    );

    always #2 clk = ~clk;

    // Expected values from the requirements
    function automatic longint f_hi(longint f);
        return (f / 25 == 0) ? 1 : f / 25;
    endfunction
    function automatic longint f_lo(longint f, longint p);
        longint mn, mx, c, h;
        h  = f_hi(f);
        mn = f / 20;
        mx = (f * 60 > 64'hFFFF_FFFF) ? 64'hFFFF_FFFF : f * 60;
        c  = (p < mn) ? mn : ((p > mx) ? mx : p);
        return (c > h) ? c - h : 1;
    endfunction

    task automatic check(bit ok, string tag, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Bench model of the schedule
    longint m_ref = REF0;
    longint m_hi = f_hi(REF0);
    longint m_lo = REF0 - f_hi(REF0);
    bit     m_pend = 0;
    longint p_hi, p_lo;
    longint exp_hi_cur, exp_lo_cur;
    longint t = 0, last_t = 0, since_rel = 0;
    longint last_hi_len = 0, last_lo_len = 0;
    int     n_rises = 0, n_falls = 0;
    logic   prev = 1'b0;

    // Phase monitor: every phase length is checked
    always @(negedge clk) begin
        t++;
        if (!rst_n) begin
            since_rel = 0;
            prev = 1'b0;
        end else begin
            since_rel++;
            if (gate_o && !prev) begin
                if (n_rises == 0)
                    check(since_rel == f_hi(REF0) + 1, "R2 first rise time", since_rel, f_hi(REF0) + 1);
                else begin
                    last_lo_len = t - last_t;
                    check(last_lo_len == exp_lo_cur, "R4 R7 low phase length", last_lo_len, exp_lo_cur);
                end
                exp_hi_cur = m_hi;
                n_rises++;
                last_t = t;
            end else if (!gate_o && prev) begin
                last_hi_len = t - last_t;
                check(last_hi_len == exp_hi_cur, "R4 R7 high phase length", last_hi_len, exp_hi_cur);
                exp_lo_cur = m_lo;
                if (m_pend) begin
                    m_hi = p_hi;
                    m_lo = p_lo;
                    m_pend = 0;
                end
                n_falls++;
                last_t = t;
            end
            prev = gate_o;
        end
    end

    task automatic write_reg(bit sel, longint data);
        @(negedge clk); #1;
        cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = 32'(data);
        @(negedge clk); #1;
        cfg_wr = 1'b0;
    endtask

    task automatic set_ref(longint f);
        write_reg(1'b1, f);
        m_ref = f;
        repeat (60) @(negedge clk);
    endtask

    task automatic wait_falls(int n);
        int target;
        target = n_falls + n;
        wait (n_falls >= target);
        @(negedge clk);
    endtask

    // Write a period right after a phase edge (in_low selects which)
    task automatic set_period(longint p, bit in_low);
        int r;
        if (in_low) begin
            r = n_falls;
            wait (n_falls > r);
        end else begin
            r = n_rises;
            wait (n_rises > r);
        end
        write_reg(1'b0, p);
        p_hi = f_hi(m_ref);
        p_lo = f_lo(m_ref, p);
        m_pend = 1;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        check(gate_o == 1'b0, "R1 gate low in reset", gate_o, 0);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(gate_o == 1'b0, "R1 gate low after release", gate_o, 0);

        // Default schedule
        wait_falls(2);
        check(last_hi_len == f_hi(REF0), "R1 default high", last_hi_len, f_hi(REF0));
        check(last_lo_len == REF0 - f_hi(REF0), "R1 default low", last_lo_len, REF0 - f_hi(REF0));

        // Writes during recalculation are dropped
        write_reg(1'b1, 300);
        write_reg(1'b1, 900);
        write_reg(1'b0, 500);
        m_ref = 300;
        repeat (60) @(negedge clk);
        wait_falls(2);
        check(last_hi_len == f_hi(REF0), "R8 ignored period write high", last_hi_len, f_hi(REF0));
        check(last_lo_len == REF0 - f_hi(REF0), "R8 ignored period write low", last_lo_len, REF0 - f_hi(REF0));
        set_period(400, 1'b0);
        wait_falls(3);
        check(last_hi_len == 12, "R8 R5 first frequency kept", last_hi_len, 12);
        check(last_lo_len == f_lo(300, 400), "R6 low from period", last_lo_len, f_lo(300, 400));

        // Update placed in a low phase: next high still old (R7)
        set_ref(400);
        set_period(700, 1'b1);
        wait_falls(3);
        check(last_hi_len == f_hi(400), "R7 write in low", last_hi_len, f_hi(400));
        check(last_lo_len == f_lo(400, 700), "R7 write in low, low", last_lo_len, f_lo(400, 700));

        // Random settings
        void'($urandom(32'd1234));
        for (int i = 0; i < 8; i++) begin
            longint f, p;
            bit in_low;
            f = 250 + longint'($urandom % 351);
            p = 1 + longint'($urandom % (f * 2));
            in_low = (i % 2 == 1) && (m_lo >= 10);
            set_ref(f);
            set_period(p, in_low);
            wait_falls(3);
            check(last_hi_len == f_hi(f), "R5 random high", last_hi_len, f_hi(f));
            check(last_lo_len == f_lo(f, p), "R6 random low", last_lo_len, f_lo(f, p));
        end

        // Clamp at the floor and at the ceiling
        set_ref(250);
        set_period(3, 1'b0);
        wait_falls(3);
        check(last_lo_len == 2, "R6 clamp to floor", last_lo_len, 2);
        set_period(100000, 1'b0);
        wait_falls(3);
        check(last_lo_len == 14990, "R6 clamp to ceiling", last_lo_len, 14990);

        // Tiny frequency: high 2, low floored at 1
        set_ref(50);
        set_period(2, 1'b0);
        wait_falls(3);
        check(last_hi_len == 2, "R5 tiny high", last_hi_len, 2);
        check(last_lo_len == 1, "R6 low floor of one", last_lo_len, 1);
        check(m_pend == 0, "R9 pending consumed", m_pend, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule